// File: doc/BRIEF.md
# Local-Side Bus Master Handshake Engine

This block drives master read and write bursts on behalf of simple local user logic. The local side asks for a transaction with a one-cycle start pulse. The block then acknowledges the request with an active-low address acknowledge. During that cycle it takes the transaction address from the 32-bit local address/data input, the command from the 4-bit command input and the burst length from the length input. It then runs the data phase toward an abstracted remote bus. The remote bus side consists of a request, an initiator-ready output, a target-ready input and the two data paths.

In the data phase a word crosses the bus at a rising edge when the block's initiator-ready and the target's ready are both high. Initiator-ready is high only while the local side holds its active-low ready input low. Local waits therefore turn into bus waits in both directions. During reads, these are the only bus waits the block itself creates. The local ready seen at an edge decides the word that moves at that edge. The local side learns the result one cycle later through the active-low transfer strobe. The active-low data acknowledge reports whether the target was ready at the last edge. It rises after every target wait.

The state sequence is IDLE, then ADDR_ACK for exactly one cycle, then DATA, then DONE for one cycle, then back to IDLE. The transitions are:
- start: IDLE to ADDR_ACK.
- zero_len: ADDR_ACK to DONE.
- go: ADDR_ACK to DATA.
- last_word: DATA to DONE, on the move of the final word.
- retire: DONE to IDLE.

Top module: `lmh_master_core`

## Requirements
- R1: During and after a synchronous active-high reset, the block is in IDLE with `adr_ack_n`, `dat_ack_n` and `xfr_n` high and `bus_req` and `bus_irdy` low.
- R2: A high `start` sampled at an edge in IDLE drives `adr_ack_n` low for exactly the following cycle (the ADDR_ACK state).
- R3: `loc_adi` and `loc_cmd` sampled at the edge that ends the ADDR_ACK cycle appear on `bus_addr` and `bus_cmd` from the next cycle on and stay unchanged until the next ADDR_ACK. `bus_cmd` bit 0 selects the direction: 1 means write, 0 means read.
- R4: `bus_req` is high exactly while the block is in DATA. DONE lasts one cycle and is followed by IDLE, in which `bus_req` is low and `adr_ack_n` is high.
- R5: In DATA, `bus_irdy` equals the inverse of `loc_rdy_n`, so a high local ready inserts a bus wait during reads and writes. A bus word moves at an edge where `bus_req`, `bus_irdy` and `bus_trdy` are all high.
- R6: `dat_ack_n` is low in a cycle exactly when the previous edge saw the block in DATA with `bus_trdy` high. It is high after every target wait.
- R7: `xfr_n` is low in the cycle after each bus word move and at no other time. Equivalently, it is low when `loc_rdy_n` was low at the previous DATA edge and `dat_ack_n` is low now.
- R8: In a write, `bus_wdata` carries `loc_adi`, so words reach the bus in the order the local side offers them, one new word after each low `xfr_n`.
- R9: In a read, `loc_dato` takes the value of `bus_rdata` at each word move and holds it while `xfr_n` is low, preserving bus order.
- R10: A burst of length N (1 or more) gives exactly N low `xfr_n` cycles and then ends. A length of 0 goes from ADDR_ACK to DONE without raising `bus_req` or `xfr_n`.
- R11: `start` has no effect outside IDLE: `adr_ack_n` stays high and the running burst continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Local request pulse for a new transaction |
| burst_len | input | 8 | Word count, sampled in the ADDR_ACK cycle |
| loc_adi | input | 32 | Local address (ADDR_ACK) and write data (DATA) |
| loc_cmd | input | 4 | Transaction command, sampled in the ADDR_ACK cycle |
| loc_rdy_n | input | 1 | Local ready, active low |
| adr_ack_n | output | 1 | Address acknowledge, active low |
| dat_ack_n | output | 1 | Data acknowledge, active low |
| xfr_n | output | 1 | Local word transferred strobe, active low |
| loc_dato | output | 32 | Read data toward the local side |
| bus_req | output | 1 | Bus data phase request |
| bus_irdy | output | 1 | Initiator ready toward the bus |
| bus_trdy | input | 1 | Target ready from the bus |
| bus_addr | output | 32 | Captured transaction address |
| bus_cmd | output | 4 | Captured transaction command |
| bus_wdata | output | 32 | Write data toward the bus |
| bus_rdata | input | 32 | Read data from the bus |

## Verification
The assertions check the following on every cycle:
- ADDR_ACK lasts one cycle.
- Start is ignored while busy.
- The strobe equals the registered local ready combined with the data acknowledge.
- A target wait always raises the acknowledge.
- Captured address and command stay stable.
- Read data is captured at each word move.

Only the bench scenarios can show the properties that span a whole burst:
- Exactly N strobes occur for random local and target wait patterns.
- Zero-length bursts behave as R10 requires.
- Write and read data keep their order end to end.

// File: rtl/lmh_pkg.sv
package lmh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ADDR_ACK = 2'd1,
        ST_DATA     = 2'd2,
        ST_DONE     = 2'd3
    } lmh_state_e;
endpackage

// File: rtl/lmh_ctrl.sv
module lmh_ctrl
    import lmh_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             loc_rdy_n_i,
    input  logic             bus_trdy_i,
    output lmh_state_e       state_o,
    output logic             fire_o,
    output logic             bus_req_o,
    output logic             bus_irdy_o,
    output logic             adr_ack_n_o,
    output logic             dat_ack_n_o,
    output logic             xfr_n_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    lmh_state_e       state_q, state_d;
    logic [LEN_W-1:0] left_q;
    logic             fire;

    assign fire       = (state_q == ST_DATA) && !loc_rdy_n_i && bus_trdy_i;
    assign fire_o     = fire;
    assign state_o    = state_q;
    assign bus_req_o  = (state_q == ST_DATA);
    assign bus_irdy_o = (state_q == ST_DATA) && !loc_rdy_n_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_ADDR_ACK;
            ST_ADDR_ACK: state_d = (len_i == '0) ? ST_DONE : ST_DATA;
            ST_DATA:     if (fire && left_q == ONE) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and word counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ADDR_ACK) left_q <= len_i;
            else if (fire)              left_q <= left_q - ONE;
        end
    end

    // registered local-side outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            adr_ack_n_o <= 1'b1;
            dat_ack_n_o <= 1'b1;
            xfr_n_o     <= 1'b1;
        end else begin
            adr_ack_n_o <= !(state_d == ST_ADDR_ACK);
            dat_ack_n_o <= !((state_q == ST_DATA) && bus_trdy_i);
            xfr_n_o     <= !fire;
        end
    end

    // R2
    addr_ack_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !adr_ack_n_o |=> adr_ack_n_o);
    // R11
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q != ST_IDLE) |=> adr_ack_n_o);
    // R7
    strobe_rule_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_DATA) |-> (xfr_n_o == !(!$past(loc_rdy_n_i) && !dat_ack_n_o)));
    // R6
    target_wait_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_DATA && !$past(bus_trdy_i)) |-> dat_ack_n_o);
    // R7
    strobe_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !xfr_n_o |-> (!dat_ack_n_o && (state_q == ST_DATA || state_q == ST_DONE)));
    // R10
    zero_len_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR_ACK && len_i == '0) |=> (state_q == ST_DONE && !bus_req_o));
endmodule

// File: rtl/lmh_latch.sv
module lmh_latch #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grab_i,
    input  logic [ADDR_W-1:0] adi_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              wr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            cmd_o  <= '0;
        end else if (grab_i) begin
            addr_o <= adi_i;
            cmd_o  <= cmd_i;
        end
    end

    assign wr_o = cmd_o[0];

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !grab_i |=> ($stable(addr_o) && $stable(cmd_o)));
    // R3
    addr_take_chk: assert property (@(posedge clk) disable iff (rst)
        grab_i |=> (addr_o == $past(adi_i) && cmd_o == $past(cmd_i)));
endmodule

// File: rtl/lmh_rdpath.sv
module lmh_rdpath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] dato_o
);
    always_ff @(posedge clk) begin
        if (rst)                dato_o <= '0;
        else if (fire_i && !wr_i) dato_o <= rdata_i;
    end

    // R9
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_i && !wr_i) |=> (dato_o == $past(rdata_i)));
endmodule

// File: rtl/lmh_master_core.sv
module lmh_master_core
    import lmh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [ADDR_W-1:0] loc_adi,
    input  logic [CMD_W-1:0]  loc_cmd,
    input  logic              loc_rdy_n,
    output logic              adr_ack_n,
    output logic              dat_ack_n,
    output logic              xfr_n,
    output logic [DATA_W-1:0] loc_dato,
    output logic              bus_req,
    output logic              bus_irdy,
    input  logic              bus_trdy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [CMD_W-1:0]  bus_cmd,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    lmh_state_e state;
    logic       fire;
    logic       is_wr;

    lmh_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .len_i       (burst_len),
        .loc_rdy_n_i (loc_rdy_n),
        .bus_trdy_i  (bus_trdy),
        .state_o     (state),
        .fire_o      (fire),
        .bus_req_o   (bus_req),
        .bus_irdy_o  (bus_irdy),
        .adr_ack_n_o (adr_ack_n),
        .dat_ack_n_o (dat_ack_n),
        .xfr_n_o     (xfr_n)
    );

    lmh_latch #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) latch_i (
        .clk    (clk),
        .rst    (rst),
        .grab_i (state == ST_ADDR_ACK),
        .adi_i  (loc_adi),
        .cmd_i  (loc_cmd),
        .addr_o (bus_addr),
        .cmd_o  (bus_cmd),
        .wr_o   (is_wr)
    );

    lmh_rdpath #(.DATA_W(DATA_W)) rdpath_i (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .wr_i    (is_wr),
        .rdata_i (bus_rdata),
        .dato_o  (loc_dato)
    );

    assign bus_wdata = loc_adi[DATA_W-1:0];

    // R4
    req_in_data_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE && !bus_req && adr_ack_n));
endmodule

// File: tb/lmh_master_core_tb.sv
module lmh_master_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  burst_len = '0;
    logic [31:0] loc_adi = '0;
    logic [3:0]  loc_cmd = '0;
    logic        loc_rdy_n = 1'b1;
    logic        bus_trdy = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        adr_ack_n, dat_ack_n, xfr_n, bus_req, bus_irdy;
    logic [31:0] loc_dato, bus_addr, bus_wdata;
    logic [3:0]  bus_cmd;

    int total = 0;
    int bad = 0;
    int burst_no = 0;

    lmh_master_core dut_i (
        .clk(clk), .rst(rst), .start(start), .burst_len(burst_len),
        .loc_adi(loc_adi), .loc_cmd(loc_cmd), .loc_rdy_n(loc_rdy_n),
        .adr_ack_n(adr_ack_n), .dat_ack_n(dat_ack_n), .xfr_n(xfr_n),
        .loc_dato(loc_dato), .bus_req(bus_req), .bus_irdy(bus_irdy),
        .bus_trdy(bus_trdy), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] wr_word(int b, int i);
        return {8'(b), 8'hC3, 16'(i * 37 + 5)};
    endfunction

    function automatic logic [31:0] rd_word(int b, int i);
        return {16'(i * 91 + 3), 8'h5A, 8'(b)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_burst(bit wr, int len, int lw, int tw, bit poke_start);
        logic [31:0] addr;
        logic [3:0]  cmd;
        int strobes = 0, loc_idx = 0, bus_idx = 0, iter = 0;
        bit exp_x = 1'b0, exp_ack_n = 1'b1, poked = 1'b0;
        burst_no++;
        addr = 32'h1000_0000 + 32'(burst_no * 16);
        cmd  = wr ? 4'b0111 : 4'b0110;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        // R2: acknowledge in the cycle after start
        chk(adr_ack_n == 1'b0, "R2", "adr_ack_n low", 32'(adr_ack_n), 0);
        start = 1'b0; loc_adi = addr; loc_cmd = cmd; burst_len = 8'(len);
        loc_rdy_n = 1'b1; bus_trdy = 1'b0;
        if (len == 0) begin
            @(negedge clk);
            // R10
            chk(bus_req == 1'b0 && xfr_n == 1'b1, "R10", "zero len no data", {bus_req, xfr_n}, 32'b01);
            @(negedge clk);
            chk(bus_req == 1'b0 && adr_ack_n == 1'b1, "R10", "zero len back idle", {bus_req, adr_ack_n}, 32'b01);
            return;
        end
        while (strobes < len && iter < 5000) begin
            @(negedge clk);
            iter++;
            if (iter == 1) begin
                chk(adr_ack_n == 1'b1, "R2", "ack one cycle", 32'(adr_ack_n), 1);
                chk(bus_addr == addr, "R3", "address", bus_addr, addr);
                chk(bus_cmd == cmd, "R3", "command", 32'(bus_cmd), 32'(cmd));
                chk(bus_req == 1'b1, "R4", "req in data", 32'(bus_req), 1);
            end
            if (poked) begin
                poked = 1'b0;
                chk(adr_ack_n == 1'b1, "R11", "start ignored", 32'(adr_ack_n), 1);
            end
            if (dat_ack_n != exp_ack_n)
                chk(1'b0, "R6", "dat_ack_n", 32'(dat_ack_n), 32'(exp_ack_n));
            if (xfr_n != !exp_x)
                chk(1'b0, "R7", "xfr_n", 32'(xfr_n), 32'(!exp_x));
            if (!xfr_n) begin
                if (!wr && loc_dato != rd_word(burst_no, strobes))
                    chk(1'b0, "R9", "read order", loc_dato, rd_word(burst_no, strobes));
                strobes++;
                loc_idx++;
            end
            start = 1'b0;
            if (poke_start && iter == 3 && bus_req) begin
                start = 1'b1;
                poked = 1'b1;
            end
            loc_rdy_n = ($urandom_range(99) < 32'(lw));
            bus_trdy  = ($urandom_range(99) >= 32'(tw));
            loc_adi   = wr ? wr_word(burst_no, loc_idx) : 32'hDEAD_0000;
            bus_rdata = rd_word(burst_no, bus_idx);
            #1;
            if (bus_req && bus_irdy != !loc_rdy_n)
                chk(1'b0, "R5", "irdy follows local ready", 32'(bus_irdy), 32'(!loc_rdy_n));
            exp_ack_n = !(bus_req && bus_trdy);
            exp_x = bus_req && bus_irdy && bus_trdy;
            if (exp_x) begin
                if (wr && bus_wdata != wr_word(burst_no, bus_idx))
                    chk(1'b0, "R8", "write order", bus_wdata, wr_word(burst_no, bus_idx));
                bus_idx++;
            end
        end
        start = 1'b0;
        // R10
        chk(strobes == len, "R10", "strobe count", 32'(strobes), 32'(len));
        chk(bus_idx == len, "R5", "bus word count", 32'(bus_idx), 32'(len));
        @(negedge clk);
        chk(xfr_n == 1'b1 && bus_req == 1'b0 && adr_ack_n == 1'b1, "R4", "idle after done",
            {xfr_n, bus_req, adr_ack_n}, 32'b101);
        chk(dat_ack_n == 1'b1, "R6", "ack high after burst", 32'(dat_ack_n), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1
        chk(adr_ack_n && dat_ack_n && xfr_n, "R1", "reset handshakes high",
            {adr_ack_n, dat_ack_n, xfr_n}, 32'b111);
        chk(!bus_req && !bus_irdy, "R1", "reset bus idle", {bus_req, bus_irdy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(adr_ack_n == 1'b1, "R1", "idle after reset", 32'(adr_ack_n), 1);
        run_burst(1'b1, 1, 0, 0, 1'b0);
        run_burst(1'b0, 4, 0, 0, 1'b0);
        run_burst(1'b1, 0, 0, 0, 1'b0);
        run_burst(1'b0, 0, 0, 0, 1'b0);
        run_burst(1'b1, 6, 80, 0, 1'b1);
        run_burst(1'b0, 6, 80, 0, 1'b1);
        run_burst(1'b1, 6, 0, 80, 1'b0);
        run_burst(1'b0, 6, 0, 80, 1'b0);
        for (int k = 0; k < 30; k++)
            run_burst(k[0], 1 + $urandom_range(19), $urandom_range(60), $urandom_range(60), k[1]);
        run_burst(1'b1, 255, 20, 20, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule